// File: doc/BRIEF.md
# Buffer descriptor stream sequencer

This block is the per-stream engine of an audio-style DMA channel. Software places a list of 16-byte descriptors in a small descriptor memory, tells the engine where the list starts, which entry is the last valid one, and how long the cyclic buffer is. It then sets the run bit. The engine fetches each descriptor's four words, splits the descriptor's byte count into beats on a byte-count data handshake, and keeps a running byte offset inside the cyclic buffer. After the last valid entry it goes back to entry 0, so it loops until it is stopped.

A descriptor whose flags word requests it raises a completion flag when its final beat is accepted. A zero-length descriptor raises a descriptor error and halts the engine. An external FIFO error pulse raises a third flag. The three flags are write-1-to-clear, and each has an enable bit that feeds one registered interrupt line. A stream reset bit holds the engine, the position and the flags at zero for as long as it is set. Software sees the bit read back as 1, then as 0 once it has cleared it, and only then programs the stream.

Top module: `bdl_stream_seq`

## Requirements
- R1: The control register (offset 0) reads back what was written: bit 0 stream reset, bit 1 run, bits 4:2 interrupt enables (completion, FIFO error, descriptor error), bits 23:20 a 4-bit stream tag presented on `xfer_tag`. A written reset bit reads back as 1, and as 0 after it is cleared.
- R2: While stream reset is set, the position, the descriptor index and all status flags are held at 0, no beat is offered, and a FIFO error pulse is ignored.
- R3: Descriptor n is read from word addresses base+4n .. base+4n+3, in the order address low, address high, byte length, flags. Flags bit 0 requests completion status. The descriptor memory answers one cycle after `desc_rd`.
- R4: A descriptor is moved as beats of min(BEAT_BYTES, remaining) bytes. The first beat's address is {high,low}, and each later address is the previous one plus the bytes of the previous beat. An offered beat holds its address and size until `xfer_ready`.
- R5: After the descriptor whose index equals the last-valid-index register, the engine continues with descriptor 0.
- R6: The position register adds the bytes of each accepted beat. When the sum reaches or passes the cyclic length it has that length subtracted, so it stays below the length.
- R7: When the last beat of a descriptor with flags bit 0 set is accepted, status bit 2 is set.
- R8: A descriptor with length 0 sets status bit 4. The engine then offers no beat and does not move the position until run is cleared.
- R9: Clearing run lets the current descriptor finish, then idles at the next descriptor and keeps the position.
- R10: Writing 1 to status bits 2, 3 or 4 clears that bit only. A set event in the same cycle wins.
- R11: A pulse on `fifo_err` sets status bit 3. Status bit 5 reads the `fifo_ready` input while not in stream reset.
- R12: `irq` is high one cycle after any status flag is set whose enable bit is set, and low one cycle after none is.
- R13: Register offsets on `reg_addr`: 0 control, 1 status, 2 position (read only), 3 cyclic length, 4 last valid index, 5 descriptor list base (word address). Reads return data one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data of the addressed register |
| desc_rd | output | 1 | Descriptor memory read request |
| desc_addr | output | DESC_AW | Descriptor memory word address |
| desc_rdata | input | 32 | Descriptor memory data, one cycle after the request |
| xfer_valid | output | 1 | Beat offered on the data port |
| xfer_addr | output | 64 | Byte address of the offered beat |
| xfer_bytes | output | $clog2(BEAT_BYTES+1) | Byte count of the offered beat |
| xfer_ready | input | 1 | Data port accepts the offered beat |
| xfer_tag | output | 4 | Stream tag from the control register |
| fifo_ready | input | 1 | FIFO ready indication mirrored in status |
| fifo_err | input | 1 | FIFO error pulse |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the engine with BEAT_BYTES of 16 and a 4-bit descriptor index. With these values, descriptor lengths of a few dozen bytes already span several beats, including a final partial beat and one-byte descriptors. The beat sequence through a full wrap of a three-entry list fits in a short capture. A cyclic length shorter than the descriptor total puts the subtracting wrap of the position within reach. Stalling `xfer_ready` at chosen beats places the run-clear pause and the stream reset exactly mid-descriptor.

// File: rtl/bds_pkg.sv
package bds_pkg;

  typedef enum logic [2:0] {
    EN_IDLE,
    EN_FETCH,
    EN_LAST,
    EN_CHECK,
    EN_XFER,
    EN_HALT
  } eng_state_t;

  localparam logic [2:0] RA_CTL  = 3'd0;
  localparam logic [2:0] RA_STS  = 3'd1;
  localparam logic [2:0] RA_POS  = 3'd2;
  localparam logic [2:0] RA_CBL  = 3'd3;
  localparam logic [2:0] RA_LVI  = 3'd4;
  localparam logic [2:0] RA_BASE = 3'd5;

  localparam int CB_SRST = 0;
  localparam int CB_RUN  = 1;
  localparam int IB_LO   = 2;
  localparam int IB_HI   = 4;
  localparam int SB_FRDY = 5;
  localparam int TAG_LO  = 20;
  localparam int TAG_W   = 4;

endpackage

// File: rtl/bds_regs.sv
module bds_regs
  import bds_pkg::*;
#(
  parameter int LEN_W   = 32,
  parameter int IDX_W   = 8,
  parameter int DESC_AW = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr,
  input  logic [2:0]         addr,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  input  logic [LEN_W-1:0]   pos,
  input  logic               fifo_ready,
  input  logic               fifo_err,
  input  logic               ioc_set,
  input  logic               derr_set,
  output logic               srst,
  output logic               run,
  output logic [TAG_W-1:0]   tag,
  output logic [LEN_W-1:0]   cbl,
  output logic [IDX_W-1:0]   lvi,
  output logic [DESC_AW-1:0] base,
  output logic               irq
);

  localparam int NFLG = IB_HI - IB_LO + 1;

  logic               srst_q, run_q, irq_q;
  logic [NFLG-1:0]    en_q, sts_q, clr;
  logic [TAG_W-1:0]   tag_q;
  logic [LEN_W-1:0]   cbl_q;
  logic [IDX_W-1:0]   lvi_q;
  logic [DESC_AW-1:0] base_q;
  logic [31:0]        rdata_q, rd_mux;

  always_comb begin
    clr = (wr && addr == RA_STS) ? wdata[IB_HI:IB_LO] : '0;
  end

  always_comb begin
    rd_mux = '0;
    unique case (addr)
      RA_CTL: begin
        rd_mux[CB_SRST]                 = srst_q;
        rd_mux[CB_RUN]                  = run_q;
        rd_mux[IB_HI:IB_LO]             = en_q;
        rd_mux[TAG_LO+TAG_W-1:TAG_LO]   = tag_q;
      end
      RA_STS: begin
        rd_mux[IB_HI:IB_LO] = sts_q;
        rd_mux[SB_FRDY]     = fifo_ready & ~srst_q;
      end
      RA_POS:  rd_mux = 32'(pos);
      RA_CBL:  rd_mux = 32'(cbl_q);
      RA_LVI:  rd_mux = 32'(lvi_q);
      RA_BASE: rd_mux = 32'(base_q);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      srst_q  <= 1'b0;
      run_q   <= 1'b0;
      en_q    <= '0;
      tag_q   <= '0;
      cbl_q   <= '0;
      lvi_q   <= '0;
      base_q  <= '0;
      sts_q   <= '0;
      irq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (wr && addr == RA_CTL) begin
        srst_q <= wdata[CB_SRST];
        run_q  <= wdata[CB_RUN];
        en_q   <= wdata[IB_HI:IB_LO];
        tag_q  <= wdata[TAG_LO+TAG_W-1:TAG_LO];
      end
      if (wr && addr == RA_CBL)  cbl_q  <= LEN_W'(wdata);
      if (wr && addr == RA_LVI)  lvi_q  <= IDX_W'(wdata);
      if (wr && addr == RA_BASE) base_q <= DESC_AW'(wdata);
      if (srst_q) sts_q <= '0;
      else        sts_q <= (sts_q & ~clr) | {derr_set, fifo_err, ioc_set};
      irq_q   <= |(sts_q & en_q);
      rdata_q <= rd_mux;
    end
  end

  assign srst  = srst_q;
  assign run   = run_q;
  assign tag   = tag_q;
  assign cbl   = cbl_q;
  assign lvi   = lvi_q;
  assign base  = base_q;
  assign irq   = irq_q;
  assign rdata = rdata_q;

  // R2: flags stay cleared through stream reset
  a_r2_sts_cleared: assert property (@(posedge clk) disable iff (rst)
    srst_q |=> (sts_q == '0));
  // R12: no flag pending means no interrupt on the next cycle
  a_r12_irq_quiet: assert property (@(posedge clk) disable iff (rst)
    (sts_q == '0) |=> !irq_q);
  // R7 / R10: a completion event is never lost to a same-cycle clear
  a_r7_ioc_sets: assert property (@(posedge clk) disable iff (rst)
    (ioc_set && !srst_q) |=> sts_q[0]);

endmodule

// File: rtl/bds_pos.sv
module bds_pos #(
  parameter int LEN_W  = 32,
  parameter int BEAT_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              srst,
  input  logic [LEN_W-1:0]  cbl,
  input  logic              adv,
  input  logic [BEAT_W-1:0] adv_bytes,
  output logic [LEN_W-1:0]  pos
);

  logic [LEN_W-1:0] pos_q;
  logic [LEN_W:0]   sum;

  always_comb begin
    sum = {1'b0, pos_q} + (LEN_W+1)'(adv_bytes);
  end

  always_ff @(posedge clk) begin
    if (rst || srst) begin
      pos_q <= '0;
    end else if (adv) begin
      if (sum >= {1'b0, cbl}) pos_q <= LEN_W'(sum - {1'b0, cbl});
      else                    pos_q <= LEN_W'(sum);
    end
  end

  assign pos = pos_q;

  // R2: position is zero after a cycle of stream reset
  a_r2_pos_zero: assert property (@(posedge clk) disable iff (rst)
    srst |=> (pos_q == '0));
  // R6: an in-range position stays in range across an accepted beat
  a_r6_in_range: assert property (@(posedge clk) disable iff (rst || srst)
    (adv && pos_q < cbl && (LEN_W+1)'(adv_bytes) <= {1'b0, cbl}) |=> (pos_q < $past(cbl)));

endmodule

// File: rtl/bds_engine.sv
module bds_engine
  import bds_pkg::*;
#(
  parameter int LEN_W      = 32,
  parameter int IDX_W      = 8,
  parameter int DESC_AW    = 10,
  parameter int BEAT_BYTES = 64,
  parameter int BEAT_W     = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               srst,
  input  logic               run,
  input  logic [IDX_W-1:0]   lvi,
  input  logic [DESC_AW-1:0] base,
  output logic               desc_rd,
  output logic [DESC_AW-1:0] desc_addr,
  input  logic [31:0]        desc_rdata,
  output logic               xfer_valid,
  output logic [63:0]        xfer_addr,
  output logic [BEAT_W-1:0]  xfer_bytes,
  input  logic               xfer_ready,
  output logic               adv,
  output logic               ioc_set,
  output logic               derr_set
);

  localparam logic [LEN_W-1:0] BEAT_L = LEN_W'(BEAT_BYTES);

  eng_state_t       st_q;
  logic [IDX_W-1:0] idx_q, idx_nxt;
  logic [1:0]       fcnt_q, rd_word_q;
  logic             rd_pend_q;
  logic [31:0]      f_lo_q, f_hi_q, f_len_q, f_flg_q;
  logic [LEN_W-1:0] rem_q, chunk;
  logic [63:0]      xaddr_q;
  logic             beat_fire, beat_last;

  always_comb begin
    chunk     = (rem_q < BEAT_L) ? rem_q : BEAT_L;
    beat_last = (rem_q <= BEAT_L);
    beat_fire = (st_q == EN_XFER) && xfer_ready;
    idx_nxt   = (idx_q == lvi) ? '0 : idx_q + 1'b1;
  end

  assign desc_rd    = (st_q == EN_FETCH);
  assign desc_addr  = base + (DESC_AW'(idx_q) << 2) + DESC_AW'(fcnt_q);
  assign xfer_valid = (st_q == EN_XFER);
  assign xfer_addr  = xaddr_q;
  assign xfer_bytes = BEAT_W'(chunk);
  assign adv        = beat_fire;
  assign ioc_set    = beat_fire && beat_last && f_flg_q[0];
  assign derr_set   = (st_q == EN_CHECK) && (f_len_q == '0);

  always_ff @(posedge clk) begin
    if (rst || srst) begin
      st_q      <= EN_IDLE;
      idx_q     <= '0;
      fcnt_q    <= '0;
      rd_word_q <= '0;
      rd_pend_q <= 1'b0;
      f_lo_q    <= '0;
      f_hi_q    <= '0;
      f_len_q   <= '0;
      f_flg_q   <= '0;
      rem_q     <= '0;
      xaddr_q   <= '0;
    end else begin
      rd_pend_q <= (st_q == EN_FETCH);
      rd_word_q <= fcnt_q;
      if (rd_pend_q) begin
        unique case (rd_word_q)
          2'd0:    f_lo_q  <= desc_rdata;
          2'd1:    f_hi_q  <= desc_rdata;
          2'd2:    f_len_q <= desc_rdata;
          default: f_flg_q <= desc_rdata;
        endcase
      end
      unique case (st_q)
        EN_IDLE: begin
          if (run) begin
            st_q   <= EN_FETCH;
            fcnt_q <= '0;
          end
        end
        EN_FETCH: begin
          fcnt_q <= fcnt_q + 1'b1;
          if (fcnt_q == 2'd3) st_q <= EN_LAST;
        end
        EN_LAST:  st_q <= EN_CHECK;
        EN_CHECK: begin
          if (f_len_q == '0) begin
            st_q <= EN_HALT;
          end else begin
            rem_q   <= LEN_W'(f_len_q);
            xaddr_q <= {f_hi_q, f_lo_q};
            st_q    <= EN_XFER;
          end
        end
        EN_XFER: begin
          if (beat_fire) begin
            rem_q   <= rem_q - chunk;
            xaddr_q <= xaddr_q + 64'(chunk);
            if (beat_last) begin
              idx_q <= idx_nxt;
              st_q  <= run ? EN_FETCH : EN_IDLE;
            end
          end
        end
        EN_HALT: if (!run) st_q <= EN_IDLE;
        default: st_q <= EN_IDLE;
      endcase
    end
  end

  // R4: every offered beat carries between one and BEAT_BYTES bytes
  a_r4_beat_size: assert property (@(posedge clk) disable iff (rst)
    xfer_valid |-> (xfer_bytes != '0 && xfer_bytes <= BEAT_W'(BEAT_BYTES)));
  // R4: a stalled beat keeps its address and size
  a_r4_beat_hold: assert property (@(posedge clk) disable iff (rst || srst)
    (xfer_valid && !xfer_ready) |=> (xfer_valid && $stable(xfer_addr) && $stable(xfer_bytes)));
  // R8: a zero-length descriptor is followed by no beat
  a_r8_halt: assert property (@(posedge clk) disable iff (rst || srst)
    derr_set |=> !xfer_valid);

endmodule

// File: rtl/bdl_stream_seq.sv
module bdl_stream_seq
  import bds_pkg::*;
#(
  parameter int LEN_W      = 32,
  parameter int IDX_W      = 8,
  parameter int DESC_AW    = 10,
  parameter int BEAT_BYTES = 64,
  localparam int BEAT_W    = $clog2(BEAT_BYTES + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic [2:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               desc_rd,
  output logic [DESC_AW-1:0] desc_addr,
  input  logic [31:0]        desc_rdata,
  output logic               xfer_valid,
  output logic [63:0]        xfer_addr,
  output logic [BEAT_W-1:0]  xfer_bytes,
  input  logic               xfer_ready,
  output logic [3:0]         xfer_tag,
  input  logic               fifo_ready,
  input  logic               fifo_err,
  output logic               irq
);

  logic               srst, run, adv, ioc_set, derr_set;
  logic [TAG_W-1:0]   tag;
  logic [LEN_W-1:0]   cbl, pos;
  logic [IDX_W-1:0]   lvi;
  logic [DESC_AW-1:0] base;

  bds_regs #(.LEN_W(LEN_W), .IDX_W(IDX_W), .DESC_AW(DESC_AW)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .pos(pos), .fifo_ready(fifo_ready), .fifo_err(fifo_err),
    .ioc_set(ioc_set), .derr_set(derr_set), .srst(srst), .run(run), .tag(tag),
    .cbl(cbl), .lvi(lvi), .base(base), .irq(irq)
  );

  bds_engine #(.LEN_W(LEN_W), .IDX_W(IDX_W), .DESC_AW(DESC_AW),
               .BEAT_BYTES(BEAT_BYTES), .BEAT_W(BEAT_W)) u_engine (
    .clk(clk), .rst(rst), .srst(srst), .run(run), .lvi(lvi), .base(base),
    .desc_rd(desc_rd), .desc_addr(desc_addr), .desc_rdata(desc_rdata),
    .xfer_valid(xfer_valid), .xfer_addr(xfer_addr), .xfer_bytes(xfer_bytes),
    .xfer_ready(xfer_ready), .adv(adv), .ioc_set(ioc_set), .derr_set(derr_set)
  );

  bds_pos #(.LEN_W(LEN_W), .BEAT_W(BEAT_W)) u_pos (
    .clk(clk), .rst(rst), .srst(srst), .cbl(cbl), .adv(adv),
    .adv_bytes(xfer_bytes), .pos(pos)
  );

  assign xfer_tag = tag;

endmodule

// File: tb/bdl_stream_seq_bench.sv
module bdl_stream_seq_bench;

  localparam int LEN_W   = 32;
  localparam int IDX_W   = 4;
  localparam int DESC_AW = 8;
  localparam int BEAT    = 16;
  localparam int BW      = $clog2(BEAT + 1);
  localparam int BASE    = 16;

  // row: {lvi[1:0], ioc[2:0], len0, len1, len2}
  localparam logic [28:0] VEC [4] = '{
    {2'd2, 3'b010, 8'd40, 8'd16, 8'd7},
    {2'd0, 3'b000, 8'd33, 8'd0,  8'd0},
    {2'd1, 3'b001, 8'd48, 8'd5,  8'd0},
    {2'd2, 3'b100, 8'd35, 8'd1,  8'd20}
  };

  logic clk = 0, rst = 1;
  logic reg_wr = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic desc_rd;
  logic [DESC_AW-1:0] desc_addr;
  logic [31:0] desc_rdata = 0;
  logic xfer_valid, xfer_ready = 1;
  logic [63:0] xfer_addr;
  logic [BW-1:0] xfer_bytes;
  logic [3:0] xfer_tag;
  logic fifo_ready = 0, fifo_err = 0, irq;

  int checks = 0, errors = 0;
  logic [31:0] mem [0:255];
  logic mon_clr = 0;
  int nb, bytes_seen;
  logic [63:0] b_addr [0:63];
  int b_bytes [0:63];

  always #5 clk = ~clk;

  bdl_stream_seq #(.LEN_W(LEN_W), .IDX_W(IDX_W), .DESC_AW(DESC_AW), .BEAT_BYTES(BEAT)) u_bdl_stream_seq (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .desc_rd(desc_rd), .desc_addr(desc_addr), .desc_rdata(desc_rdata),
    .xfer_valid(xfer_valid), .xfer_addr(xfer_addr), .xfer_bytes(xfer_bytes),
    .xfer_ready(xfer_ready), .xfer_tag(xfer_tag), .fifo_ready(fifo_ready),
    .fifo_err(fifo_err), .irq(irq)
  );

  always @(posedge clk) if (desc_rd) desc_rdata <= mem[desc_addr];

  always @(posedge clk) begin
    if (mon_clr) begin
      nb <= 0;
      bytes_seen <= 0;
    end else if (xfer_valid && xfer_ready) begin
      if (nb < 64) begin
        b_addr[nb]  <= xfer_addr;
        b_bytes[nb] <= int'(xfer_bytes);
      end
      nb <= nb + 1;
      bytes_seen <= bytes_seen + int'(xfer_bytes);
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic restart_stream();
    wr(3'd0, 32'h1);
    wr(3'd0, 32'h0);
    @(negedge clk); mon_clr = 1;
    @(negedge clk); mon_clr = 0;
  endtask

  task automatic put_desc(input int d, input int r, input int len, input bit ioc);
    mem[BASE + 4*d + 0] = 32'h1000 * (d + 1);
    mem[BASE + 4*d + 1] = 32'(r);
    mem[BASE + 4*d + 2] = 32'(len);
    mem[BASE + 4*d + 3] = {31'b0, ioc};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 256; i++) mem[i] = 0;
    mon_clr = 1;
    repeat (3) @(negedge clk);
    rst = 0; mon_clr = 0;

    // reset state (R2, R13)
    rd(3'd0, v); check("R13 ctl after reset", v, 0);
    rd(3'd1, v); check("R2 sts after reset", v, 0);
    rd(3'd2, v); check("R2 pos after reset", v, 0);
    check("R12 irq after reset", irq, 0);
    check("R2 no beat after reset", xfer_valid, 0);

    // R1 reset handshake and field readback
    wr(3'd0, 32'h1);
    rd(3'd0, v); check("R1 reset reads 1", v, 32'h1);
    wr(3'd0, 32'h0);
    rd(3'd0, v); check("R1 reset reads 0", v, 32'h0);
    wr(3'd0, 32'h0050_001C);
    rd(3'd0, v); check("R1 tag and enables", v, 32'h0050_001C);
    check("R1 tag on port", xfer_tag, 4'h5);
    wr(3'd0, 32'h0);

    // vector table: R3 R4 R5 R6 R7 R9
    for (int r = 0; r < 4; r++) begin
      int lvi, cbl, k;
      int L [3];
      logic [2:0] ioc;
      bit ok, any_ioc;
      lvi = int'(VEC[r][28:27]);
      ioc = VEC[r][26:24];
      L[0] = int'(VEC[r][23:16]);
      L[1] = int'(VEC[r][15:8]);
      L[2] = int'(VEC[r][7:0]);
      cbl = 0; any_ioc = 0;
      for (int d = 0; d <= lvi; d++) begin
        put_desc(d, r, L[d], ioc[d]);
        cbl += L[d];
        any_ioc |= ioc[d];
      end
      restart_stream();
      wr(3'd3, 32'(cbl));
      wr(3'd4, 32'(lvi));
      wr(3'd5, 32'(BASE));
      wr(3'd0, 32'h2);
      while (bytes_seen <= cbl) @(negedge clk);
      xfer_ready = 0;
      wr(3'd0, 32'h0);
      xfer_ready = 1;
      idle(30);
      ok = 1; k = 0;
      for (int p = 0; p < 2; p++) begin
        for (int d = 0; d <= (p == 0 ? lvi : 0); d++) begin
          for (int off = 0; off < L[d]; off += BEAT) begin
            logic [63:0] ea;
            int eb;
            ea = {32'(r), 32'h1000 * (d + 1)} + 64'(off);
            eb = (L[d] - off < BEAT) ? L[d] - off : BEAT;
            if (k >= nb || b_addr[k] !== ea || b_bytes[k] != eb) ok = 0;
            k++;
          end
        end
      end
      check("R4 R5 beat sequence", {63'b0, ok} & {63'b0, (k == nb)}, 1);
      check("R9 bytes moved before pause", bytes_seen, cbl + L[0]);
      rd(3'd2, v); check("R6 R9 position kept at pause", v, (cbl + L[0]) % cbl);
      rd(3'd1, v); check("R7 completion flag", v, any_ioc ? 32'h4 : 32'h0);
    end

    // R12 interrupt enable and R10 clear
    wr(3'd0, 32'h4);
    idle(2);
    check("R12 irq raised", irq, 1);
    wr(3'd1, 32'h4);
    idle(2);
    check("R12 irq dropped", irq, 0);
    rd(3'd1, v); check("R10 completion cleared", v, 0);

    // R11 / R10 selective clear
    @(negedge clk); fifo_err = 1;
    @(negedge clk); fifo_err = 0;
    rd(3'd1, v); check("R11 fifo error flag", v, 32'h8);
    wr(3'd1, 32'h4);
    rd(3'd1, v); check("R10 other flag kept", v, 32'h8);
    wr(3'd1, 32'h8);
    rd(3'd1, v); check("R10 fifo flag cleared", v, 0);
    fifo_ready = 1;
    rd(3'd1, v); check("R11 fifo ready bit", v, 32'h20);
    fifo_ready = 0;
    wr(3'd0, 32'h0);

    // R8 zero-length descriptor
    restart_stream();
    put_desc(0, 9, 0, 1'b0);
    wr(3'd3, 32'd10);
    wr(3'd4, 32'd0);
    wr(3'd0, 32'h2);
    idle(20);
    rd(3'd1, v); check("R8 descriptor error flag", v, 32'h10);
    check("R8 no beats", nb, 0);
    rd(3'd2, v); check("R8 position unchanged", v, 0);
    wr(3'd0, 32'h0);

    // R6 subtracting wrap and R9 pause mid-descriptor
    restart_stream();
    put_desc(0, 7, 40, 1'b0);
    wr(3'd3, 32'd30);
    xfer_ready = 0;
    wr(3'd0, 32'h2);
    idle(10);
    wr(3'd0, 32'h0);
    xfer_ready = 1;
    idle(30);
    check("R9 one descriptor then idle", bytes_seen, 40);
    rd(3'd2, v); check("R6 position wrapped by length", v, 10);

    // R2 stream reset mid-run holds everything at zero
    restart_stream();
    put_desc(0, 7, 40, 1'b0);
    wr(3'd3, 32'd40);
    wr(3'd0, 32'h2);
    while (bytes_seen < 16) @(negedge clk);
    wr(3'd0, 32'h3);
    idle(2);
    check("R2 beats stop in reset", xfer_valid, 0);
    @(negedge clk); fifo_err = 1;
    @(negedge clk); fifo_err = 0;
    rd(3'd2, v); check("R2 position held", v, 0);
    rd(3'd1, v); check("R2 fifo error ignored", v, 0);
    rd(3'd0, v); check("R1 reset reads 1 while running", v, 32'h3);
    wr(3'd0, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule